// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

The block is a synchronous up-counter built from identical 4-bit stages. The stages share one clock and one set of control inputs. Each stage takes two active-high count enables. Only one of them, the trickle enable, is passed on to gate the stage's terminal-count output. Each stage's terminal count drives the trickle enable of the stage above it, so the stages carry without any ripple through the clock. An active-low parallel load captures a data word, and an active-low clear zeros the whole count. A parameter sets whether the clear acts at once (asynchronous) or on the next rising edge (synchronous).

The top module chains a parameter-set number of stages into one wide counter. It can also truncate the count at an optional modulus. When the modulus is non-zero, the counter returns to zero on the enabled edge after it reaches modulus-1. The terminal-count output then marks modulus-1 instead of all ones. This lets a second counter of the same kind extend the first.

Top module: `casc_counter`

## Requirements
- R1: With clear and load inactive (both high) and both count enables high, the count rises by one on each rising clock edge. The carry passes between stages, and all ones wraps to zero.
- R2: With clear and load inactive, a low on either count enable leaves the count unchanged across the edge.
- R3: A low on load_ni captures data_i into the count on the next rising edge, whatever the levels of both count enables.
- R4: In synchronous-clear mode (CLR_MODE = CLR_SYNC), a low on rst_ni zeros the count on the next rising edge, and the count does not change before that edge. The clear takes priority over load and both enables.
- R5: In asynchronous-clear mode (CLR_MODE = CLR_ASYNC), a low on rst_ni forces the count to zero immediately, without waiting for a clock edge, and it overrides load and the enables.
- R6: tc_o is high exactly when cnt_en_t_i is high and the count equals the terminal value. The terminal value is all ones (4095 at the defaults), or MODULUS-1 when MODULUS is non-zero. tc_o follows cnt_en_t_i combinationally, and cnt_en_p_i has no effect on it.
- R7: An upper stage advances only on an enabled edge where every stage below it holds all ones (15). Otherwise the upper stages keep their value.
- R8: With MODULUS non-zero, an enabled count edge with load inactive and the count at MODULUS-1 returns the count to zero. A load of any value, including values at or above MODULUS, still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock shared by all stages |
| rst_ni | input | 1 | Active-low clear; asynchronous or synchronous per CLR_MODE |
| load_ni | input | 1 | Active-low parallel load |
| data_i | input | NUM_STAGES*STAGE_W | Load value |
| cnt_en_p_i | input | 1 | Count enable that does not affect tc_o |
| cnt_en_t_i | input | 1 | Count enable that also gates tc_o |
| count_o | output | NUM_STAGES*STAGE_W | Current count |
| tc_o | output | 1 | Terminal-count flag |

## Verification
The assertions assume that load_ni, data_i and both enables are stable around each rising edge. In asynchronous mode they also assume that rst_ni is never released at a rising edge. The stimulus respects both by changing every input at the falling edge, half a period away from the active edge. The property checks for increment, hold and load are switched off while the clear is low, because the clear wins in every case. The stimulus mixes directed runs with random sequences. The directed runs cover a stage carry, a full wrap, a modulus wrap, and a clear applied together with a load. The random sequences bias the load values toward all ones and toward the modulus boundary.

// File: rtl/casc_cnt_pkg.sv
package casc_cnt_pkg;
  typedef enum logic {
    CLR_ASYNC = 1'b0,
    CLR_SYNC  = 1'b1
  } clr_mode_e;
endpackage

// File: rtl/casc_cnt_next.sv
module casc_cnt_next #(
  parameter int W = 4
) (
  input  logic [W-1:0] cur_i,
  input  logic         load_ni,
  input  logic [W-1:0] data_i,
  input  logic         inc_i,
  output logic [W-1:0] nxt_o
);
  always_comb begin
    if (!load_ni)   nxt_o = data_i;
    else if (inc_i) nxt_o = cur_i + 1'b1;
    else            nxt_o = cur_i;
  end
endmodule

// File: rtl/casc_cnt_stage.sv
module casc_cnt_stage
  import casc_cnt_pkg::*;
#(
  parameter int        STAGE_W  = 4,
  parameter clr_mode_e CLR_MODE = CLR_SYNC
) (
  input  logic               clk_i,
  input  logic               clr_ni,
  input  logic               load_ni,
  input  logic [STAGE_W-1:0] data_i,
  input  logic               en_p_i,
  input  logic               en_t_i,
  output logic [STAGE_W-1:0] q_o,
  output logic               tc_o
);
  logic               inc;
  logic [STAGE_W-1:0] nxt;

  assign inc = en_p_i & en_t_i;

  casc_cnt_next #(.W(STAGE_W)) next_i (
    .cur_i  (q_o),
    .load_ni(load_ni),
    .data_i (data_i),
    .inc_i  (inc),
    .nxt_o  (nxt)
  );

  if (CLR_MODE == CLR_SYNC) begin : g_sync_clr
    always_ff @(posedge clk_i) begin
      if (!clr_ni) q_o <= '0;
      else         q_o <= nxt;
    end

    p_sync_clr_r4: assert property (@(posedge clk_i)
      !clr_ni |=> q_o == '0);
  end else begin : g_async_clr
    always_ff @(posedge clk_i or negedge clr_ni) begin
      if (!clr_ni) q_o <= '0;
      else         q_o <= nxt;
    end

    p_async_clr_r5: assert property (@(posedge clk_i)
      !clr_ni |-> q_o == '0);
  end

  // carry look-ahead: trickle enable fed forward
  assign tc_o = en_t_i & (&q_o);

  p_inc_r1: assert property (@(posedge clk_i) disable iff (!clr_ni)
    load_ni && en_p_i && en_t_i |=> q_o == STAGE_W'($past(q_o) + 1'b1));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!clr_ni)
    load_ni && !(en_p_i && en_t_i) |=> $stable(q_o));

  p_load_r3: assert property (@(posedge clk_i) disable iff (!clr_ni)
    !load_ni |=> q_o == $past(data_i));
endmodule

// File: rtl/casc_cnt_wrap.sv
module casc_cnt_wrap #(
  parameter int W       = 12,
  parameter int MODULUS = 0
) (
  input  logic [W-1:0] count_i,
  input  logic         load_ni,
  input  logic [W-1:0] data_i,
  input  logic         en_p_i,
  input  logic         en_t_i,
  input  logic         chain_tc_i,
  output logic         load_no,
  output logic [W-1:0] data_o,
  output logic         tc_o
);
  localparam bit         MOD_ON = MODULUS > 0;
  localparam logic [W-1:0] LAST = W'(MODULUS - 1);

  logic at_last;
  logic hit;

  assign at_last = (count_i == LAST);
  // wrap replaces the increment; an external load still wins
  assign hit     = MOD_ON && load_ni && en_p_i && en_t_i && at_last;
  assign load_no = load_ni & ~hit;
  assign data_o  = hit ? '0 : data_i;
  assign tc_o    = MOD_ON ? (en_t_i & at_last) : chain_tc_i;
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import casc_cnt_pkg::*;
#(
  parameter int        NUM_STAGES = 3,
  parameter int        STAGE_W    = 4,
  parameter clr_mode_e CLR_MODE   = CLR_SYNC,
  parameter int        MODULUS    = 0,
  localparam int       CNT_W      = NUM_STAGES * STAGE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [CNT_W-1:0] data_i,
  input  logic             cnt_en_p_i,
  input  logic             cnt_en_t_i,
  output logic [CNT_W-1:0] count_o,
  output logic             tc_o
);
  localparam logic [CNT_W-1:0] TERM = (MODULUS > 0) ? CNT_W'(MODULUS - 1) : '1;

  logic [NUM_STAGES:0] t_chain;
  logic                ld_n_int;
  logic [CNT_W-1:0]    data_int;

  assign t_chain[0] = cnt_en_t_i;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    casc_cnt_stage #(
      .STAGE_W (STAGE_W),
      .CLR_MODE(CLR_MODE)
    ) stage_i (
      .clk_i  (clk_i),
      .clr_ni (rst_ni),
      .load_ni(ld_n_int),
      .data_i (data_int[g*STAGE_W +: STAGE_W]),
      .en_p_i (cnt_en_p_i),
      .en_t_i (t_chain[g]),
      .q_o    (count_o[g*STAGE_W +: STAGE_W]),
      .tc_o   (t_chain[g+1])
    );
  end

  casc_cnt_wrap #(
    .W      (CNT_W),
    .MODULUS(MODULUS)
  ) wrap_i (
    .count_i   (count_o),
    .load_ni   (load_ni),
    .data_i    (data_i),
    .en_p_i    (cnt_en_p_i),
    .en_t_i    (cnt_en_t_i),
    .chain_tc_i(t_chain[NUM_STAGES]),
    .load_no   (ld_n_int),
    .data_o    (data_int),
    .tc_o      (tc_o)
  );

  p_tc_hi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> cnt_en_t_i && count_o == TERM);

  p_tc_lo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_t_i && count_o == TERM |-> tc_o);

  if (MODULUS == 0 && NUM_STAGES > 1) begin : g_chain_chk
    p_upper_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_ni && count_o[STAGE_W-1:0] != '1
      |=> count_o[CNT_W-1:STAGE_W] == $past(count_o[CNT_W-1:STAGE_W]));
  end

  if (MODULUS > 0) begin : g_mod_chk
    p_mod_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_ni && cnt_en_p_i && cnt_en_t_i && count_o == TERM |=> count_o == '0);
  end
endmodule

// File: tb/casc_counter_tb_top.sv
`timescale 1ns/1ps
module casc_counter_tb_top;
  import casc_cnt_pkg::*;

  localparam int W   = 12;
  localparam int MOD = 1000;

  typedef struct packed {
    logic [2:0][W-1:0] cnt;
    logic [2:0]        tc;
    logic [2:0][3:0]   code;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_n = 1'b1;
  logic [W-1:0] data = '0;
  logic         en_p = 1'b0;
  logic         en_t = 1'b0;
  logic [W-1:0] cnt_w [3];
  logic         tc_w  [3];

  int unsigned  model [3];
  int           mods  [3] = '{0, MOD, 0};
  exp_t         sb_q [$];
  int           n_chk = 0;
  int           n_fail = 0;

  always #10 clk = ~clk;

  casc_counter #(.CLR_MODE(CLR_SYNC), .MODULUS(0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data),
    .cnt_en_p_i(en_p), .cnt_en_t_i(en_t), .count_o(cnt_w[0]), .tc_o(tc_w[0]));

  casc_counter #(.CLR_MODE(CLR_SYNC), .MODULUS(MOD)) dut_mod_i (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data),
    .cnt_en_p_i(en_p), .cnt_en_t_i(en_t), .count_o(cnt_w[1]), .tc_o(tc_w[1]));

  casc_counter #(.CLR_MODE(CLR_ASYNC), .MODULUS(0)) dut_async_i (
    .clk_i(clk), .rst_ni(rst_n), .load_ni(load_n), .data_i(data),
    .cnt_en_p_i(en_p), .cnt_en_t_i(en_t), .count_o(cnt_w[2]), .tc_o(tc_w[2]));

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'd1: return "R1 increment";
      4'd2: return "R2 hold";
      4'd3: return "R3 load";
      4'd4: return "R4 sync clear";
      4'd5: return "R5 async clear";
      4'd7: return "R7 stage carry";
      4'd8: return "R8 modulo wrap";
      default: return "R6 terminal count";
    endcase
  endfunction

  function automatic int unsigned term_of(input int i);
    return (mods[i] > 0) ? mods[i] - 1 : 4095;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // driver: apply inputs at the falling edge, predict the next edge
  task automatic step(input bit clr, input bit ld, input logic [W-1:0] d,
                      input bit p, input bit t);
    exp_t e;
    @(negedge clk);
    rst_n = clr; load_n = ld; data = d; en_p = p; en_t = t;
    #2;
    if (!clr) begin
      chk(cnt_w[2] == '0, "R5 async clear immediate", cnt_w[2], 0);
      chk(cnt_w[0] == W'(model[0]), "R4 sync clear waits for edge", cnt_w[0], model[0]);
    end else begin
      chk(tc_w[0] == (t && model[0] == 4095), "R6 tc follows trickle enable",
          tc_w[0], (t && model[0] == 4095));
    end
    for (int i = 0; i < 3; i++) begin
      logic [3:0] c;
      if (!clr) begin
        c = (i == 2) ? 4'd5 : 4'd4;
        model[i] = 0;
      end else if (!ld) begin
        c = 4'd3;
        model[i] = d;
      end else if (p && t) begin
        if (mods[i] > 0 && model[i] == term_of(i)) begin
          c = 4'd8;
          model[i] = 0;
        end else begin
          c = ((model[i] & 15) == 15) ? 4'd7 : 4'd1;
          model[i] = (model[i] + 1) & 12'hFFF;
        end
      end else begin
        c = 4'd2;
      end
      e.cnt[i]  = W'(model[i]);
      e.tc[i]   = t && (model[i] == term_of(i));
      e.code[i] = c;
    end
    sb_q.push_back(e);
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        for (int i = 0; i < 3; i++) begin
          chk(cnt_w[i] == e.cnt[i], tag_of(e.code[i]), cnt_w[i], e.cnt[i]);
          chk(tc_w[i] == e.tc[i], "R6 terminal count", tc_w[i], e.tc[i]);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    for (int i = 0; i < 3; i++) model[i] = 0;
    // reset state
    step(0, 1, 0, 0, 0);
    step(1, 1, 0, 0, 0);                 // R2 hold at zero
    step(1, 0, 12'd14, 0, 0);            // R3 load, enables low
    step(1, 1, 0, 1, 1);                 // 15
    step(1, 1, 0, 1, 1);                 // R7 carry to 16
    step(1, 1, 0, 1, 1);
    step(1, 1, 0, 0, 1);                 // R2 hold, p low
    step(1, 1, 0, 1, 0);                 // R2 hold, t low
    step(1, 0, 12'd4093, 0, 0);          // R3
    step(1, 1, 0, 1, 1);                 // 4094
    step(1, 1, 0, 1, 1);                 // 4095, R6 tc high
    step(1, 1, 0, 0, 1);                 // R6 p low keeps tc
    step(1, 1, 0, 1, 0);                 // R6 t low drops tc
    step(1, 1, 0, 1, 1);                 // R1 wrap to 0
    step(1, 0, 12'd998, 1, 1);           // R3 load wins over enables
    step(1, 1, 0, 1, 1);                 // 999
    step(1, 1, 0, 1, 1);                 // R8 wrap on modulo unit
    step(1, 1, 0, 1, 1);
    step(1, 0, 12'd255, 0, 0);
    step(1, 1, 0, 1, 1);                 // R7 carry into third stage
    step(0, 0, 12'd77, 1, 1);            // R4 clear beats load
    step(1, 0, 12'd1234, 0, 0);
    step(0, 1, 0, 1, 1);                 // R4/R5 clear beats count
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] d;
      case ($urandom % 4)
        0: d = W'($urandom);
        1: d = W'(4088 + $urandom % 8);
        2: d = W'(990 + $urandom % 10);
        default: d = W'(($urandom % 256) * 16 + 14);
      endcase
      step(($urandom % 20) != 0, ($urandom % 8) != 0, d,
           ($urandom % 4) != 0, ($urandom % 4) != 0);
    end
    repeat (3) @(posedge clk);
    #6;
    summary();
  end
endmodule